// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block sets the bit timing for a CAN node. Each bit is built from four parts, counted in time quanta (TQ): a one-quantum sync part, a propagation part, a first phase part and a second phase part. Counting happens only on a time-quantum enable tick from an external prescaler. At the boundary between the two phase parts the block latches the receive line once and raises a one-clock sample strobe. It raises a one-clock bit-start strobe in every sync quantum.

The block watches the receive line for falling edges, where recessive (1) goes to dominant (0), and uses them to pull its bit clock into step with the sender. If the bus is idle, a falling edge restarts the bit at once (hard sync). During a frame, the edge's phase error is measured against the sync part. A small error also restarts the bit. A larger error stretches the first phase part or trims the second one by the programmed jump width. Frame logic, stuffing, CRC and the prescaler sit outside this block.

Top module: `can_bit_sync`

## Requirements
- R1: After reset both strobes are low and `sample_bit` is 1 (recessive). The first tick after reset is a sync quantum and raises `bit_start`.
- R2: With no usable edge, a bit lasts 1 + `prop_len` + `ph1_len` + `ph2_len` ticks, with `bit_start` in its sync quantum. Both strobes are one clock wide, in the clock after the tick that caused them. State moves only on `tq_tick`.
- R3: `sample_stb` follows the tick of the last first-phase quantum, and `sample_bit` then holds `rx_in` as seen at that tick. `sample_bit` changes at no other time.
- R4: With `bus_idle` high, a usable falling edge makes its own quantum the sync quantum of a new bit (hard sync): `bit_start` follows that tick.
- R5: An edge is usable only if the previous tick saw `rx_in`=1, this tick sees `rx_in`=0, and the last sampled bit is 1. Rising edges and edges after a dominant sample change nothing.
- R6: After any sync action (hard sync, restart, stretch or trim), all further edges are ignored until the next sync quantum reached by normal counting.
- R7: An edge in the propagation or first phase part has positive error e, with e = 1 for the first propagation quantum and one more for each later quantum. If e <= `sjw`, the edge quantum becomes the new sync quantum.
- R8: If positive e > `sjw`, the first phase part of that bit is longer by exactly `sjw` quanta, and so is the bit.
- R9: An edge in the second phase part has an error of magnitude m, equal to the quanta left in that part counting the edge quantum. If m <= `sjw`, the bit restarts there. Otherwise the second phase part is shorter by exactly `sjw`.
- R10: With `tx_dom` high and the bus not idle, an edge with positive error is ignored.
- R11: An edge in the sync quantum while the bus is not idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tq_tick | input | 1 | One-clock time-quantum enable |
| rx_in | input | 1 | Receive line, 0 = dominant |
| bus_idle | input | 1 | Bus is idle; edges cause hard sync |
| tx_dom | input | 1 | This node is sending a dominant bit |
| prop_len | input | 4 | Propagation part length, 1..8 TQ |
| ph1_len | input | 4 | First phase part length, 1..8 TQ |
| ph2_len | input | 4 | Second phase part length, 2..8 TQ, not below `sjw` |
| sjw | input | 3 | Jump width, 1..4 TQ |
| bit_start | output | 1 | Pulse in the clock after a sync quantum's tick |
| sample_stb | output | 1 | Pulse in the clock after the sample point |
| sample_bit | output | 1 | Bus value latched at the last sample point |

## Verification
Assertions check on every clock that the two strobes never coincide and only follow a tick, that the sampled bit holds between sample points, and that stretch and trim are never both pending. They also check that a restart leads straight to a bit start, that no second sync action occurs in the same bit, and that a transmitting node never reacts to a positive-error edge. Only the bench scenarios show the bit lengths that result from each error class, the value of the error at the jump-width boundary, the handling of edges that fail qualification, and how hard sync lines up with the bit stream.

// File: rtl/cbs_pkg.sv
// Shared types for the CAN bit timing synchronizer.
// Assumes: one bit time is split into four consecutive segments.
package cbs_pkg;

    // Segment of the bit time now being counted.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    // Action chosen for a qualified edge in the current quantum.
    typedef struct packed {
        logic restart;  // treat this quantum as the sync quantum
        logic grow;     // stretch phase 1 by the jump width
        logic shrink;   // trim phase 2 by the jump width
    } sync_act_t;

endpackage

// File: rtl/cbs_edge_qual.sv
// Edge qualifier: finds a recessive-to-dominant transition between
// consecutive time quanta and accepts it only if the last sampled bit
// was recessive and no sync action has yet been taken in this bit.
// Assumes rx_in is already synchronized to clk.
module cbs_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx_in,
    input  logic last_sample,
    input  logic sync_used,
    output logic edge_ok
);

    logic prev_rx;

    // Remember the line value seen at the previous quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_rx <= 1'b1;
        else if (tq_tick)
            prev_rx <= rx_in;
    end

    // Qualified falling edge in the current quantum.
    always_comb begin
        edge_ok = tq_tick & prev_rx & ~rx_in & last_sample & ~sync_used;
    end

endmodule

// File: rtl/cbs_phase_judge.sv
// Phase judge: measures the phase error of a qualified edge from the
// segment and quantum position, and picks restart, stretch or trim.
// Purely combinational. Assumes segment lengths are in their legal
// ranges and that no trim is pending while an edge can qualify.
module cbs_phase_judge
    import cbs_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LEN_W = 4,
    parameter int SJW_W = 3,
    parameter int POS_W = 5
) (
    input  seg_e             seg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw,
    input  logic             bus_idle,
    input  logic             tx_dom,
    input  logic             edge_ok,
    output sync_act_t        act
);

    logic [POS_W-1:0] lead_err;
    logic [POS_W-1:0] lag_err;
    logic [POS_W-1:0] err_mag;
    logic             early;
    logic             late;
    logic             within_jw;

    // Error magnitude: quanta since sync (early) or quanta left (late).
    always_comb begin
        early    = (seg == SEG_PROP) || (seg == SEG_PH1);
        late     = (seg == SEG_PH2);
        lead_err = (seg == SEG_PROP)
                 ? POS_W'(cnt) + POS_W'(1)
                 : POS_W'(prop_len) + POS_W'(cnt) + POS_W'(1);
        lag_err  = POS_W'(ph2_len) - POS_W'(cnt);
        err_mag  = early ? lead_err : lag_err;
        within_jw = (err_mag <= POS_W'(sjw));
    end

    // Decision for the qualified edge.
    always_comb begin
        act.restart = edge_ok & (bus_idle
                               | (late & within_jw)
                               | (early & within_jw & ~tx_dom));
        act.grow    = edge_ok & ~bus_idle & early & ~within_jw & ~tx_dom;
        act.shrink  = edge_ok & ~bus_idle & late & ~within_jw;
    end

endmodule

// File: rtl/cbs_seg_timer.sv
// Segment timer: walks sync, propagation, phase 1 and phase 2 on each
// quantum tick, applies the judged sync action, samples the line at the
// end of phase 1 and emits the bit-start and sample strobes.
// Assumes phase 2 is not shorter than the jump width.
module cbs_seg_timer
    import cbs_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LEN_W = 4,
    parameter int SJW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_in,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw,
    input  sync_act_t        act,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic             sync_used,
    output logic             bit_start,
    output logic             sample_stb,
    output logic             sample_bit
);

    logic [SJW_W-1:0] ext;
    logic [SJW_W-1:0] shr;
    logic [SJW_W-1:0] ext_n;
    logic [SJW_W-1:0] shr_n;
    logic [CNT_W-1:0] prop_last;
    logic [CNT_W-1:0] ph1_last;
    logic [CNT_W-1:0] ph2_span;
    logic [CNT_W-1:0] cnt_inc;

    // Segment end points with this quantum's adjustment already applied.
    always_comb begin
        ext_n     = act.grow   ? sjw : ext;
        shr_n     = act.shrink ? sjw : shr;
        prop_last = CNT_W'(prop_len) - CNT_W'(1);
        ph1_last  = CNT_W'(ph1_len) + CNT_W'(ext_n) - CNT_W'(1);
        ph2_span  = CNT_W'(ph2_len) - CNT_W'(shr_n);
        cnt_inc   = cnt + CNT_W'(1);
    end

    // Bit-time state machine, advanced once per quantum tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg        <= SEG_SYNC;
            cnt        <= '0;
            ext        <= '0;
            shr        <= '0;
            sync_used  <= 1'b0;
            bit_start  <= 1'b0;
            sample_stb <= 1'b0;
            sample_bit <= 1'b1;
        end else begin
            bit_start  <= 1'b0;
            sample_stb <= 1'b0;
            if (tq_tick) begin
                if (act.restart) begin
                    seg       <= SEG_PROP;
                    cnt       <= '0;
                    ext       <= '0;
                    shr       <= '0;
                    sync_used <= 1'b1;
                    bit_start <= 1'b1;
                end else begin
                    unique case (seg)
                        SEG_SYNC: begin
                            seg       <= SEG_PROP;
                            cnt       <= '0;
                            sync_used <= 1'b0;
                            bit_start <= 1'b1;
                        end
                        SEG_PROP: begin
                            if (act.grow) begin
                                ext       <= sjw;
                                sync_used <= 1'b1;
                            end
                            if (cnt == prop_last) begin
                                seg <= SEG_PH1;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt_inc;
                            end
                        end
                        SEG_PH1: begin
                            if (act.grow) begin
                                ext       <= sjw;
                                sync_used <= 1'b1;
                            end
                            if (cnt == ph1_last) begin
                                seg        <= SEG_PH2;
                                cnt        <= '0;
                                sample_stb <= 1'b1;
                                sample_bit <= rx_in;
                            end else begin
                                cnt <= cnt_inc;
                            end
                        end
                        SEG_PH2: begin
                            if (act.shrink) begin
                                shr       <= sjw;
                                sync_used <= 1'b1;
                            end
                            if (cnt_inc >= ph2_span) begin
                                seg <= SEG_SYNC;
                                cnt <= '0;
                                ext <= '0;
                                shr <= '0;
                            end else begin
                                cnt <= cnt_inc;
                            end
                        end
                        default: begin
                            seg <= SEG_SYNC;
                            cnt <= '0;
                        end
                    endcase
                end
            end
        end
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_start && sample_stb));

    // R2
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_start || sample_stb) |-> $past(tq_tick));

    // R3
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(sample_bit));

    // R8
    stretch_trim_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((ext != '0) && (shr != '0)));

    // R4
    restart_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && act.restart) |=> (bit_start && seg == SEG_PROP && cnt == '0));

    // R6
    one_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && sync_used && seg != SEG_SYNC)
            |-> !(act.restart || act.grow || act.shrink));

endmodule

// File: rtl/can_bit_sync.sv
// CAN bit timing synchronizer top: ties the edge qualifier, the phase
// judge and the segment timer together. Assumes tq_tick is a single-
// clock pulse and the segment settings change only while in reset.
module can_bit_sync
    import cbs_pkg::*;
#(
    parameter int MAX_SEG = 8,
    parameter int MAX_SJW = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tq_tick,
    input  logic                         rx_in,
    input  logic                         bus_idle,
    input  logic                         tx_dom,
    input  logic [$clog2(MAX_SEG+1)-1:0] prop_len,
    input  logic [$clog2(MAX_SEG+1)-1:0] ph1_len,
    input  logic [$clog2(MAX_SEG+1)-1:0] ph2_len,
    input  logic [$clog2(MAX_SJW+1)-1:0] sjw,
    output logic                         bit_start,
    output logic                         sample_stb,
    output logic                         sample_bit
);

    localparam int LEN_W = $clog2(MAX_SEG + 1);
    localparam int SJW_W = $clog2(MAX_SJW + 1);
    localparam int CNT_W = $clog2(MAX_SEG + MAX_SJW + 1);
    localparam int POS_W = $clog2(2 * MAX_SEG + MAX_SJW + 2);

    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic             sync_used;
    logic             edge_ok;
    sync_act_t        act;

    cbs_edge_qual u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tq_tick    (tq_tick),
        .rx_in      (rx_in),
        .last_sample(sample_bit),
        .sync_used  (sync_used),
        .edge_ok    (edge_ok)
    );

    cbs_phase_judge #(
        .CNT_W(CNT_W), .LEN_W(LEN_W), .SJW_W(SJW_W), .POS_W(POS_W)
    ) u_judge (
        .seg     (seg),
        .cnt     (cnt),
        .prop_len(prop_len),
        .ph2_len (ph2_len),
        .sjw     (sjw),
        .bus_idle(bus_idle),
        .tx_dom  (tx_dom),
        .edge_ok (edge_ok),
        .act     (act)
    );

    cbs_seg_timer #(
        .CNT_W(CNT_W), .LEN_W(LEN_W), .SJW_W(SJW_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_tick   (tq_tick),
        .rx_in     (rx_in),
        .prop_len  (prop_len),
        .ph1_len   (ph1_len),
        .ph2_len   (ph2_len),
        .sjw       (sjw),
        .act       (act),
        .seg       (seg),
        .cnt       (cnt),
        .sync_used (sync_used),
        .bit_start (bit_start),
        .sample_stb(sample_stb),
        .sample_bit(sample_bit)
    );

    // R10
    tx_dom_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && tx_dom && !bus_idle && (seg == SEG_PROP || seg == SEG_PH1))
            |-> !(act.restart || act.grow));

    // R11
    sync_quantum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && !bus_idle && seg == SEG_SYNC) |-> !(act.restart || act.grow || act.shrink));

    // R5
    rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && rx_in) |-> !(act.restart || act.grow || act.shrink));

endmodule

// File: tb/can_bit_sync_bench.sv
// Bench: directed bit sequences and seeded random stimulus, checked
// against a quantum-position reference model kept in the bench.
module can_bit_sync_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       bus_idle = 1'b0;
    logic       tx_dom = 1'b0;
    logic [3:0] prop_len = 4'd2;
    logic [3:0] ph1_len = 4'd3;
    logic [3:0] ph2_len = 4'd3;
    logic [2:0] sjw = 3'd1;
    logic       bit_start;
    logic       sample_stb;
    logic       sample_bit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int m_pos, m_ext, m_shr;
    bit m_flag, m_prev, m_samp;
    bit e_bs, e_ss;
    bit obs_bs;

    always #10 clk = ~clk;

    can_bit_sync u_can_bit_sync (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_in(rx_in),
        .bus_idle(bus_idle), .tx_dom(tx_dom), .prop_len(prop_len),
        .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw(sjw),
        .bit_start(bit_start), .sample_stb(sample_stb), .sample_bit(sample_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pos = 0; m_ext = 0; m_shr = 0;
        m_flag = 0; m_prev = 1; m_samp = 1;
    endtask

    // Reference: advance one quantum from the requirements R2..R11.
    task automatic model_step(input bit r);
        int p, f, s, j, lead_end, blen, mag;
        bit usable, rs;
        p = int'(prop_len); f = int'(ph1_len); s = int'(ph2_len); j = int'(sjw);
        usable = m_prev && !r && m_samp && !m_flag;
        rs = 0; e_bs = 0; e_ss = 0;
        lead_end = p + f + m_ext;
        if (usable && bus_idle) rs = 1;
        else if (usable && m_pos != 0) begin
            if (m_pos <= lead_end) begin
                if (!tx_dom) begin
                    if (m_pos <= j) rs = 1;
                    else begin m_ext = j; m_flag = 1; end
                end
            end else begin
                mag = 1 + lead_end + s - m_pos;
                if (mag <= j) rs = 1;
                else begin m_shr = j; m_flag = 1; end
            end
        end
        if (rs) begin
            e_bs = 1; m_pos = 1; m_flag = 1; m_ext = 0; m_shr = 0;
        end else begin
            lead_end = p + f + m_ext;
            blen = 1 + lead_end + s - m_shr;
            if (m_pos == 0) begin e_bs = 1; m_flag = 0; end
            if (m_pos == lead_end) begin e_ss = 1; m_samp = r; end
            if (m_pos == blen - 1) begin m_pos = 0; m_ext = 0; m_shr = 0; end
            else m_pos++;
        end
        m_prev = r;
    endtask

    // One quantum tick, entered and left at a falling clock edge.
    task automatic do_tick(input bit r, input int gap);
        rx_in = r;
        tq_tick = 1'b1;
        model_step(r);
        @(negedge clk);
        tq_tick = 1'b0;
        obs_bs = bit_start;
        chk(bit_start === e_bs, "R2 bit_start", int'(bit_start), int'(e_bs));
        chk(sample_stb === e_ss, "R3 sample_stb", int'(sample_stb), int'(e_ss));
        chk(sample_bit === m_samp, "R3 sample_bit", int'(sample_bit), int'(m_samp));
        for (int g = 0; g <= gap; g++) begin
            @(negedge clk);
            chk(!bit_start && !sample_stb, "R2 one-clock strobe",
                int'({bit_start, sample_stb}), 0);
        end
    endtask

    // Drive n quanta with rx from pat; bit_start expected at 0 and rs_at.
    task automatic drive_bit(input int n, input logic [31:0] pat, input int rs_at,
                             input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            do_tick(pat[i], 0);
            if (obs_bs != ((i == 0) || (i == rs_at))) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        tq_tick = 1'b0;
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(!bit_start && !sample_stb && sample_bit, "R1 reset state",
            int'({bit_start, sample_stb, sample_bit}), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // Directed: prop 2, ph1 3, ph2 3, sjw 1 -> nominal bit of 9 quanta.
        prop_len = 4'd2; ph1_len = 4'd3; ph2_len = 4'd3; sjw = 3'd1;
        bus_idle = 1'b1;
        apply_reset();
        drive_bit(9, 32'hFFFF_FFFF, -1, "R1 first bit");
        drive_bit(9, 32'hFFFF_FFFF, -1, "R2 nominal idle bit");
        drive_bit(11, 32'h0000_0003, 2, "R4 hard sync at quantum 2");
        bus_idle = 1'b0;
        drive_bit(9, 32'hFFFF_FFFF, -1, "R2 nominal bit");
        drive_bit(10, 32'h0000_000F, -1, "R8 phase 1 stretched");
        drive_bit(9, 32'hFFFF_FFFF, -1, "R5 rising edge ignored");
        drive_bit(8, 32'h0000_003F, -1, "R9 phase 2 trimmed");
        drive_bit(9, 32'hFFFF_FFFF, -1, "R2 nominal bit");
        drive_bit(10, 32'h0000_0005, 1, "R7 restart and R6 second edge ignored");
        drive_bit(9, 32'hFFFF_FFFF, -1, "R2 nominal bit");
        tx_dom = 1'b1;
        drive_bit(9, 32'h0000_000F, -1, "R10 positive edge ignored");
        tx_dom = 1'b0;
        drive_bit(9, 32'h0000_000F, -1, "R5 edge after dominant sample");
        drive_bit(9, 32'hFFFF_FFFF, -1, "R2 nominal bit");
        drive_bit(9, 32'h0000_0000, -1, "R11 edge in sync quantum");
        drive_bit(9, 32'hFFFF_FFFF, -1, "R2 nominal bit");
        drive_bit(17, 32'h0000_00FF, 8, "R9 small negative restart");

        // Random configurations and traffic.
        for (int c = 0; c < 6; c++) begin
            int lo;
            bit r;
            sjw = 3'(1 + $urandom % 4);
            prop_len = 4'(1 + $urandom % 8);
            ph1_len = 4'(1 + $urandom % 8);
            lo = (int'(sjw) < 2) ? 2 : int'(sjw);
            ph2_len = 4'(lo + $urandom % (9 - lo));
            bus_idle = 1'b0; tx_dom = 1'b0;
            apply_reset();
            r = 1'b1;
            for (int t = 0; t < 2500; t++) begin
                if ($urandom % 6 == 0) r = ~r;
                bus_idle = ($urandom % 16 == 0);
                tx_dom = ($urandom % 4 == 0);
                do_tick(r, $urandom % 3);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule